// File: doc/BRIEF.md
# Serial Command Decoder and Register Bank

This block is the host-facing front end of a serial-bus word transmitter. A controller reaches it over a four-wire SPI link in mode 0 (clock idles low, data sampled on rising edges). After chip select falls, the first eight bits form a command byte. The command byte selects one of the following:

- a short register write (clock divisor or configuration word);
- a register read shifted out on the serial output;
- an open-ended stream of 32-bit transmit words;
- a one-shot command.

The one-shot commands are reset-all, FIFO flush and transmit start.

The SPI pins are asynchronous to the block. They are passed through a synchronizer and edge detector, and all decoding runs on the system clock. The block keeps three pieces of state: the 16-bit configuration word, the 8-bit divisor, and a status byte assembled from the FIFO flags. It hands single-cycle strobes and a 32-bit data word to the FIFO and transmit logic next to it. It stores no FIFO data itself.

Top module: `spi_cmd_regs`

## Requirements
- R1: The command byte is taken from the first 8 rising SCK edges after chip select goes low, most significant bit first. Raising chip select at any point abandons the command in progress.
- R2: Command 0x10 loads the next 16 bits, MSB first, into the configuration word. Command 0x07 loads the next 8 bits into the divisor. A field that is cut short by chip select rising leaves the register unchanged. Bits clocked in after the field is complete are ignored.
- R3: Commands 0x0B (configuration, 16 bits), 0x0C (divisor, 8 bits) and 0x0A (status, 8 bits) shift their value out on SO, MSB first. The MSB becomes valid at the falling SCK edge after the 8th command bit, and each later falling edge presents the next bit.
- R4: The status byte has FIFO-empty at bit 3, half-full at bit 4 and full at bit 5. Bits 0 to 2, 6 and 7 read 0.
- R5: Commands 0x01 (reset-all) and 0x11 (FIFO flush) each raise their own strobe for exactly one clock, while chip select is still low, right after the 8th command bit. No two strobes are ever high together.
- R6: Command 0x12 raises the start strobe only when configuration bit 13 is 0. When bit 13 is 1, the command does nothing.
- R7: The reset-all command leaves both the configuration word and the divisor unchanged.
- R8: Under command 0x0E, every complete 32-bit group raises the FIFO write strobe for one clock, with the word (first bit received at bit 31) on the write-data port. A group left incomplete at chip select rise produces no write.
- R9: Any other command value raises no strobe, changes no register and never enables SO.
- R10: The SO enable is low whenever chip select is high, and is high only while a read command is active.
- R11: After system reset the configuration word and divisor are 0, all strobes are low and SO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sck | input | 1 | SPI serial clock (asynchronous) |
| cs_n | input | 1 | SPI chip select, active low (asynchronous) |
| si | input | 1 | SPI serial data in |
| fifo_empty | input | 1 | Transmit FIFO holds no words |
| fifo_half | input | 1 | Transmit FIFO holds at least half its depth |
| fifo_full | input | 1 | Transmit FIFO has no free slot |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Drive enable for SO; the pad is high-impedance when low |
| cfg_q | output | 16 | Configuration word |
| div_q | output | 8 | Clock divisor value |
| rst_all | output | 1 | One-clock reset-all strobe |
| fifo_clr | output | 1 | One-clock FIFO flush strobe |
| tx_start | output | 1 | One-clock transmit start strobe |
| fifo_wr | output | 1 | One-clock FIFO write strobe |
| fifo_wdata | output | 32 | Word delivered with the FIFO write strobe |

## Verification
The in-line assertions check these properties on every cycle:

- the strobes are mutually exclusive and each lasts one clock;
- a start strobe never occurs while configuration bit 13 is set;
- the SO enable falls once chip select is seen high;
- the configuration word is unchanged across a reset-all strobe;
- FIFO writes happen only inside a selected transfer.

The directed scenarios cover what needs a whole transfer to observe:

- the bit order of writes and read-back;
- the status bit positions under different flag patterns;
- aborted and over-long fields;
- streamed FIFO words with a trailing partial word;
- strobes arriving before chip select rises;
- the complete absence of effects from undefined commands.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   localparam int OP_W = 8;

   typedef enum logic [OP_W-1:0] {
      OP_RST_ALL = 8'h01,
      OP_WR_DIV  = 8'h07,
      OP_RD_STAT = 8'h0A,
      OP_RD_CFG  = 8'h0B,
      OP_RD_DIV  = 8'h0C,
      OP_LOAD    = 8'h0E,
      OP_WR_CFG  = 8'h10,
      OP_FLUSH   = 8'h11,
      OP_GO      = 8'h12
   } spi_op_e;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_WR   = 2'd1,
      PH_RD   = 2'd2,
      PH_IDLE = 2'd3
   } phase_e;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_idle,
   output logic si_s
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_in_sync: STAGES must be at least 2");
   end

   // bit 2 = sck, bit 1 = cs_n, bit 0 = si
   localparam logic [2:0] RST_VAL = 3'b010;

   logic [2:0] chain [STAGES];
   logic       sck_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= {sck, cs_n, si};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= chain[STAGES-1][2];
   end

   assign sck_rise = chain[STAGES-1][2] & ~sck_d;
   assign sck_fall = ~chain[STAGES-1][2] & sck_d;
   assign cs_idle  = chain[STAGES-1][1];
   assign si_s     = chain[STAGES-1][0];
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
   parameter int CFG_W = 16,
   parameter int DIV_W = 8,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              div_we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              fifo_empty,
   input  logic              fifo_half,
   input  logic              fifo_full,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [DIV_W-1:0]  div_q,
   output logic [7:0]        stat
);
   if (CFG_W > WORD_W || DIV_W > WORD_W) begin : g_bad_width
      $error("spi_cmd_regfile: register wider than the shift word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         div_q <= '0;
      end else begin
         if (cfg_we) cfg_q <= wdata[CFG_W-1:0];
         if (div_we) div_q <= wdata[DIV_W-1:0];
      end
   end

   // status byte layout is fixed: empty=3, half=4, full=5
   assign stat = {2'b00, fifo_full, fifo_half, fifo_empty, 3'b000};

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/spi_cmd_core.sv
module spi_cmd_core
   import spi_cmd_pkg::*;
#(
   parameter int CFG_W     = 16,
   parameter int DIV_W     = 8,
   parameter int WORD_W    = 32,
   parameter int GO_BLOCK  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_idle,
   input  logic              si_s,
   input  logic [CFG_W-1:0]  cfg_q,
   input  logic [DIV_W-1:0]  div_q,
   input  logic [7:0]        stat,
   output logic              so,
   output logic              so_oe,
   output logic              cfg_we,
   output logic              div_we,
   output logic [WORD_W-1:0] wdata,
   output logic              rst_all,
   output logic              fifo_clr,
   output logic              tx_start,
   output logic              fifo_wr
);
   localparam int RD_W  = (CFG_W > DIV_W) ? ((CFG_W > 8) ? CFG_W : 8)
                                          : ((DIV_W > 8) ? DIV_W : 8);
   localparam int CNT_W = $clog2(WORD_W + 1);

   if (GO_BLOCK >= CFG_W) begin : g_bad_gate
      $error("spi_cmd_core: GO_BLOCK outside configuration word");
   end

   phase_e          phase;
   logic [CNT_W-1:0] bcnt;
   logic [CNT_W-1:0] wr_len;
   logic [OP_W-1:0] op_sh;
   logic [OP_W-1:0] op_q;
   logic [RD_W-1:0] rd_sh;
   logic            rd_hold;
   logic [OP_W-1:0] op_next;
   logic [WORD_W-1:0] wr_next;

   assign op_next = {op_sh[OP_W-2:0], si_s};
   assign wr_next = {wdata[WORD_W-2:0], si_s};
   assign so      = rd_sh[RD_W-1];
   assign so_oe   = (phase == PH_RD) && !cs_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         bcnt     <= '0;
         wr_len   <= '0;
         op_sh    <= '0;
         op_q     <= '0;
         rd_sh    <= '0;
         rd_hold  <= 1'b0;
         wdata    <= '0;
         cfg_we   <= 1'b0;
         div_we   <= 1'b0;
         rst_all  <= 1'b0;
         fifo_clr <= 1'b0;
         tx_start <= 1'b0;
         fifo_wr  <= 1'b0;
      end else begin
         cfg_we   <= 1'b0;
         div_we   <= 1'b0;
         rst_all  <= 1'b0;
         fifo_clr <= 1'b0;
         tx_start <= 1'b0;
         fifo_wr  <= 1'b0;
         if (cs_idle) begin
            phase   <= PH_CMD;
            bcnt    <= '0;
            rd_hold <= 1'b0;
         end else if (sck_rise) begin
            unique case (phase)
               PH_CMD: begin
                  op_sh <= op_next;
                  if (bcnt == CNT_W'(OP_W - 1)) begin
                     bcnt  <= '0;
                     op_q  <= op_next;
                     phase <= PH_IDLE;
                     case (op_next)
                        OP_RST_ALL: rst_all  <= 1'b1;
                        OP_FLUSH:   fifo_clr <= 1'b1;
                        OP_GO:      tx_start <= ~cfg_q[GO_BLOCK];
                        OP_WR_DIV: begin
                           phase  <= PH_WR;
                           wr_len <= CNT_W'(DIV_W);
                        end
                        OP_WR_CFG: begin
                           phase  <= PH_WR;
                           wr_len <= CNT_W'(CFG_W);
                        end
                        OP_LOAD: begin
                           phase  <= PH_WR;
                           wr_len <= CNT_W'(WORD_W);
                        end
                        OP_RD_STAT: begin
                           phase   <= PH_RD;
                           rd_hold <= 1'b1;
                           rd_sh   <= RD_W'(stat) << (RD_W - 8);
                        end
                        OP_RD_CFG: begin
                           phase   <= PH_RD;
                           rd_hold <= 1'b1;
                           rd_sh   <= RD_W'(cfg_q) << (RD_W - CFG_W);
                        end
                        OP_RD_DIV: begin
                           phase   <= PH_RD;
                           rd_hold <= 1'b1;
                           rd_sh   <= RD_W'(div_q) << (RD_W - DIV_W);
                        end
                        default: ;
                     endcase
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               PH_WR: begin
                  wdata <= wr_next;
                  if (bcnt == wr_len - 1'b1) begin
                     bcnt <= '0;
                     case (op_q)
                        OP_WR_DIV: begin div_we <= 1'b1; phase <= PH_IDLE; end
                        OP_WR_CFG: begin cfg_we <= 1'b1; phase <= PH_IDLE; end
                        default:   fifo_wr <= 1'b1;
                     endcase
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end else if (sck_fall && phase == PH_RD) begin
            if (rd_hold) rd_hold <= 1'b0;
            else         rd_sh   <= rd_sh << 1;
         end
      end
   end

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_all, fifo_clr, tx_start, fifo_wr}));
   // R5
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_all || fifo_clr || tx_start) |=> !(rst_all || fifo_clr || tx_start));
   // R6
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !cfg_q[GO_BLOCK]);
   // R8
   load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |=> !fifo_wr);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs #(
   parameter int SYNC_STAGES = 2,
   parameter int CFG_W       = 16,
   parameter int DIV_W       = 8,
   parameter int WORD_W      = 32,
   parameter int GO_BLOCK    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              si,
   input  logic              fifo_empty,
   input  logic              fifo_half,
   input  logic              fifo_full,
   output logic              so,
   output logic              so_oe,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              rst_all,
   output logic              fifo_clr,
   output logic              tx_start,
   output logic              fifo_wr,
   output logic [WORD_W-1:0] fifo_wdata
);
   logic       sck_rise, sck_fall, cs_idle, si_s;
   logic       cfg_we, div_we;
   logic [7:0] stat;

   spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .si_s(si_s)
   );

   spi_cmd_core #(.CFG_W(CFG_W), .DIV_W(DIV_W), .WORD_W(WORD_W),
                  .GO_BLOCK(GO_BLOCK)) u_core (
      .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_idle(cs_idle), .si_s(si_s), .cfg_q(cfg_q), .div_q(div_q),
      .stat(stat), .so(so), .so_oe(so_oe), .cfg_we(cfg_we), .div_we(div_we),
      .wdata(fifo_wdata), .rst_all(rst_all), .fifo_clr(fifo_clr),
      .tx_start(tx_start), .fifo_wr(fifo_wr)
   );

   spi_cmd_regfile #(.CFG_W(CFG_W), .DIV_W(DIV_W), .WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .div_we(div_we),
      .wdata(fifo_wdata), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
      .fifo_full(fifo_full), .cfg_q(cfg_q), .div_q(div_q), .stat(stat)
   );

   // R10
   so_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |-> !so_oe);
   // R7
   rst_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_all |=> ($stable(cfg_q) && $stable(div_q)));
   // R8
   load_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> !cs_idle);
endmodule

// File: tb/tb_spi_cmd_regs.sv
module tb_spi_cmd_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
   logic        fifo_empty = 1'b0, fifo_half = 1'b0, fifo_full = 1'b0;
   logic        so, so_oe, rst_all, fifo_clr, tx_start, fifo_wr;
   logic [15:0] cfg_q;
   logic [7:0]  div_q;
   logic [31:0] fifo_wdata;

   int vecs = 0, errs = 0;
   int n_rst = 0, n_clr = 0, n_go = 0, n_wr = 0;
   logic [31:0] wq [8];

   always #2 clk = ~clk;

   spi_cmd_regs dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_full(fifo_full),
      .so(so), .so_oe(so_oe), .cfg_q(cfg_q), .div_q(div_q),
      .rst_all(rst_all), .fifo_clr(fifo_clr), .tx_start(tx_start),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
   );

   always @(posedge clk) begin
      if (rst_all)  n_rst <= n_rst + 1;
      if (fifo_clr) n_clr <= n_clr + 1;
      if (tx_start) n_go  <= n_go + 1;
      if (fifo_wr) begin
         if (n_wr < 8) wq[n_wr] <= fifo_wdata;
         n_wr <= n_wr + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_lo();
      cs_n = 1'b0;
      idle(8);
   endtask

   task automatic cs_hi();
      idle(8);
      cs_n = 1'b1;
      idle(12);
   endtask

   // send v[n-1:0] MSB first; collect SO sampled just before each rise
   task automatic shift(input int n, input logic [31:0] v,
                        output logic [31:0] r);
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         si = v[i];
         idle(8);
         r = {r[30:0], so};
         sck = 1'b1;
         idle(8);
         sck = 1'b0;
      end
   endtask

   task automatic put(input int n, input logic [31:0] v);
      logic [31:0] r;
      shift(n, v, r);
   endtask

   task automatic t_reset();
      chk(cfg_q == 16'h0, "R11 cfg", 32'(cfg_q), 0);
      chk(div_q == 8'h0, "R11 div", 32'(div_q), 0);
      chk(!so_oe && !rst_all && !fifo_clr && !tx_start && !fifo_wr,
          "R11 outputs", {so_oe, rst_all, fifo_clr, tx_start, fifo_wr}, 0);
   endtask

   task automatic t_write_read();
      logic [31:0] r;
      cs_lo(); put(8, 32'h10); put(16, 32'h2C5A); cs_hi();
      chk(cfg_q == 16'h2C5A, "R2 cfg write", 32'(cfg_q), 32'h2C5A);
      cs_lo(); put(8, 32'h07); put(8, 32'h5A); put(4, 32'hF); cs_hi();
      chk(div_q == 8'h5A, "R2 div extra bits", 32'(div_q), 32'h5A);
      cs_lo(); put(8, 32'h0B); shift(16, 0, r);
      chk(so_oe, "R10 so_oe during read", 32'(so_oe), 1);
      cs_hi();
      chk(r[15:0] == 16'h2C5A, "R3 cfg read", r, 32'h2C5A);
      chk(!so_oe, "R10 so_oe after read", 32'(so_oe), 0);
      cs_lo(); put(8, 32'h0C); shift(8, 0, r); cs_hi();
      chk(r[7:0] == 8'h5A, "R3 div read", r, 32'h5A);
      cs_lo(); put(8, 32'h10); put(9, 32'h1FF); cs_hi();
      chk(cfg_q == 16'h2C5A, "R2 aborted write", 32'(cfg_q), 32'h2C5A);
      cs_lo(); put(5, 32'h1F); cs_hi();
      cs_lo(); put(8, 32'h10); put(16, 32'h8001); cs_hi();
      chk(cfg_q == 16'h8001, "R1 restart after abort", 32'(cfg_q), 32'h8001);
   endtask

   task automatic t_status();
      logic [31:0] r;
      fifo_empty = 1'b1; fifo_half = 1'b0; fifo_full = 1'b0;
      cs_lo(); put(8, 32'h0A); shift(8, 0, r); cs_hi();
      chk(r[7:0] == 8'h08, "R4 status empty", r, 32'h08);
      fifo_empty = 1'b0; fifo_half = 1'b1; fifo_full = 1'b1;
      cs_lo(); put(8, 32'h0A); shift(8, 0, r); cs_hi();
      chk(r[7:0] == 8'h30, "R4 status half+full", r, 32'h30);
      fifo_half = 1'b0; fifo_full = 1'b0;
   endtask

   task automatic t_strobes();
      int b;
      b = n_rst;
      cs_lo(); put(8, 32'h01); idle(10);
      chk(n_rst == b + 1, "R5 reset strobe before cs rise", n_rst, b + 1);
      cs_hi();
      chk(cfg_q == 16'h8001 && div_q == 8'h5A, "R7 regs kept",
          {cfg_q, div_q, 8'h0}, 32'h80015A00);
      b = n_clr;
      cs_lo(); put(8, 32'h11); idle(10);
      chk(n_clr == b + 1, "R5 flush strobe", n_clr, b + 1);
      cs_hi();
      cs_lo(); put(8, 32'h10); put(16, 32'h2000); cs_hi();
      b = n_go;
      cs_lo(); put(8, 32'h12); idle(10); cs_hi();
      chk(n_go == b, "R6 start blocked by bit 13", n_go, b);
      cs_lo(); put(8, 32'h10); put(16, 32'h0000); cs_hi();
      cs_lo(); put(8, 32'h12); idle(10);
      chk(n_go == b + 1, "R6 start when bit 13 clear", n_go, b + 1);
      cs_hi();
   endtask

   task automatic t_load();
      int b;
      b = n_wr;
      cs_lo(); put(8, 32'h0E);
      put(32, 32'hDEADBEEF); put(32, 32'h0123_4567); put(10, 32'h3FF);
      cs_hi();
      chk(n_wr == b + 2, "R8 write count", n_wr, b + 2);
      chk(wq[b] == 32'hDEADBEEF, "R8 word 0", wq[b], 32'hDEADBEEF);
      chk(wq[b+1] == 32'h01234567, "R8 word 1", wq[b+1], 32'h01234567);
   endtask

   task automatic t_undefined();
      int s;
      s = n_rst + n_clr + n_go + n_wr;
      cs_lo(); put(8, 32'h05); put(16, 32'hFFFF);
      chk(!so_oe, "R9 no SO on undefined", 32'(so_oe), 0);
      cs_hi();
      chk(n_rst + n_clr + n_go + n_wr == s, "R9 no strobe",
          n_rst + n_clr + n_go + n_wr, s);
      chk(cfg_q == 16'h0 && div_q == 8'h5A, "R9 regs unchanged",
          {cfg_q, div_q, 8'h0}, 32'h00005A00);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_write_read();
      t_status();
      t_strobes();
      t_load();
      t_undefined();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      #(200000 * 4);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule